// File: doc/BRIEF.md
# Two-Layer Pixel Compositor with Panel Reduction

This block is the per-pixel colour path of a display engine. Each accepted beat carries one pixel from each of two layers. Every layer pixel is widened to a common 32-bit alpha-plus-RGB form, and its alpha is scaled by a constant per-layer alpha. The two layers are then laid in turn over a constant background colour. The 24-bit composite is reduced to the bit width of the attached panel. On narrow panels an optional pseudo-random dither can be applied before the low bits are dropped.

The beat input and the pixel output are a valid/ready stream. The whole pipeline advances on a clock edge only when `o_ready` is high, and `i_ready` mirrors `o_ready`. When `o_ready` is low, no new beat is accepted and every stage holds, including the output word and `o_valid`. A beat offered while `i_ready` is low is not taken and has no effect. The layer format codes, enables and constant alphas, the background colour, the output width select and the dither enable are all captured together with the beat. They may change from one beat to the next.

Top module: `pix_compose`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `o_valid` is 0 and `o_pix` is 0.
- R2: The layer format codes are 0 = 32-bit alpha/R/G/B (alpha in bits 31:24, R in 23:16, G in 15:8, B in 7:0), 1 = 24-bit R/G/B in bits 23:0, and 2 = 16-bit 5/6/5 in bits 15:0. In the 5/6/5 format each channel's top bits are repeated into its empty low bits. Formats 1 and 2 have a pixel alpha of 0xFF.
- R3: The effective alpha of a layer is floor(pixel_alpha × constant_alpha / 255).
- R4: The composite starts from the background colour. Layer 1 is laid over it first, then layer 2 over that result. Each channel of each step is floor((a×fg + (255−a)×under) / 255). A layer that is disabled, or that carries format code 3, has an effective alpha of 0.
- R5: `o_pix` holds R in bits 23:16, G in 15:8 and B in 7:0. Output select 0 or 3 gives 8/8/8, 1 gives 6/6/6, and 2 gives 5/6/5. Each reduced channel sits in the top bits of its byte lane, with the dropped bits at zero.
- R6: With dithering on and a 6/6/6 or 5/6/5 output, a 2-bit noise value is added to each 8-bit channel before its low bits are dropped. The sum saturates at 0xFF. The noise comes from a 16-bit LFSR that resets to 0xACE1. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. B uses s[1:0], G uses s[3:2] and R uses s[5:4].
- R7: With dithering off, or with the 8/8/8 output, the channels are only truncated (for 8/8/8 they pass unchanged).
- R8: The LFSR advances once for every accepted beat, whether dithering is on or off. The n-th accepted beat after reset (counting from 0) uses the state reached after n advances.
- R9: With `o_ready` high, a beat accepted on one clock edge appears on `o_pix` with `o_valid` high exactly three cycles after it was presented. Back-to-back beats come out back-to-back.
- R10: `i_ready` equals `o_ready`. While `o_ready` is low, `o_valid` and `o_pix` stay unchanged, and an offered beat is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Input beat valid |
| i_ready | output | 1 | Input beat accepted when high together with i_valid |
| l1_pix | input | 32 | Layer 1 pixel word |
| l1_fmt | input | 2 | Layer 1 format code |
| l1_en | input | 1 | Layer 1 enable |
| l1_alpha | input | 8 | Layer 1 constant alpha |
| l2_pix | input | 32 | Layer 2 pixel word |
| l2_fmt | input | 2 | Layer 2 format code |
| l2_en | input | 1 | Layer 2 enable |
| l2_alpha | input | 8 | Layer 2 constant alpha |
| bg_color | input | 24 | Background colour, R/G/B |
| out_fmt | input | 2 | Panel width select |
| dith_en | input | 1 | Dither enable |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Downstream ready |
| o_pix | output | 24 | Reduced output pixel |

## Verification
Some properties are checked by assertions on every cycle. These are the three-cycle valid latency under steady ready, the freeze of the output during back-pressure, and the bounds of each blend step: the result lies between the two colours it mixes, equals the foreground at full alpha and equals the underlying colour at zero alpha. Dithering is also checked never to lower a channel below its plain truncation. The exact numeric results need the bench's directed scenarios: format widening, the alpha product, the stacking order, lane placement, the LFSR noise sequence and its saturation, and the rule that a beat refused under back-pressure leaves the noise sequence untouched.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int CW = 8;

  typedef struct packed {
    logic [CW-1:0] a;
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } argb_t;

  typedef logic [3*CW-1:0] rgb_t;

  localparam logic [1:0] FMT_ARGB8888 = 2'd0;
  localparam logic [1:0] FMT_RGB888   = 2'd1;
  localparam logic [1:0] FMT_RGB565   = 2'd2;

  localparam logic [1:0] OUT_666 = 2'd1;
  localparam logic [1:0] OUT_565 = 2'd2;
endpackage

// File: rtl/pc_expand.sv
module pc_expand
  import pc_pkg::*;
(
  input  logic [31:0] pix,
  input  logic [1:0]  fmt,
  input  logic        en,
  input  logic [7:0]  calpha,
  output argb_t       px
);
  logic [7:0]  pa;
  logic [15:0] prod;

  always_comb begin
    px = '0;
    pa = 8'hFF;
    case (fmt)
      FMT_ARGB8888: begin
        pa   = pix[31:24];
        px.r = pix[23:16];
        px.g = pix[15:8];
        px.b = pix[7:0];
      end
      FMT_RGB888: begin
        px.r = pix[23:16];
        px.g = pix[15:8];
        px.b = pix[7:0];
      end
      FMT_RGB565: begin
        px.r = {pix[15:11], pix[15:13]};
        px.g = {pix[10:5], pix[10:9]};
        px.b = {pix[4:0], pix[4:2]};
      end
      default: pa = 8'h00;
    endcase
    prod = pa * calpha;
    px.a = en ? 8'(prod / 16'd255) : 8'h00;
  end
endmodule

// File: rtl/pc_blend.sv
module pc_blend
  import pc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  argb_t fg,
  input  rgb_t  bg,
  output rgb_t  mix
);
  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [7:0]  f, u, res, lo, hi;
    logic [16:0] acc;
    assign f   = fg[c*8 +: 8];
    assign u   = bg[c*8 +: 8];
    assign acc = 17'(fg.a) * 17'(f) + 17'(8'd255 - fg.a) * 17'(u);
    assign res = 8'(acc / 17'd255);
    assign mix[c*8 +: 8] = res;
    assign lo  = (f < u) ? f : u;
    assign hi  = (f < u) ? u : f;

    p_mix_bounds_r4: assert property (@(posedge clk) disable iff (rst)
      (res >= lo) && (res <= hi));
  end

  p_opaque_r4: assert property (@(posedge clk) disable iff (rst)
    (fg.a == 8'hFF) |-> (mix == fg[23:0]));
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (fg.a == 8'h00) |-> (mix == bg));
endmodule

// File: rtl/pc_dither.sv
module pc_dither
  import pc_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  rgb_t       din,
  input  logic [1:0] ofmt,
  input  logic       den,
  output rgb_t       dout
);
  logic [15:0] lfsr;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else if (step) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [2:0] drop;
    logic [7:0] mask, res;
    logic [8:0] sum;
    logic [1:0] rnd;
    assign rnd = lfsr[2*c +: 2];

    always_comb begin
      case (ofmt)
        OUT_666: drop = 3'd2;
        OUT_565: drop = (c == 1) ? 3'd2 : 3'd3;
        default: drop = 3'd0;
      endcase
      mask = 8'hFF << drop;
      sum  = {1'b0, din[c*8 +: 8]} + ((den && drop != 3'd0) ? {7'd0, rnd} : 9'd0);
      res  = (sum[8] ? 8'hFF : sum[7:0]) & mask;
    end
    assign dout[c*8 +: 8] = res;

    p_no_drop_r6: assert property (@(posedge clk) disable iff (rst)
      res >= (din[c*8 +: 8] & mask));
  end
endmodule

// File: rtl/pix_compose.sv
module pix_compose
  import pc_pkg::*;
#(
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        i_valid,
  output logic        i_ready,
  input  logic [31:0] l1_pix,
  input  logic [1:0]  l1_fmt,
  input  logic        l1_en,
  input  logic [7:0]  l1_alpha,
  input  logic [31:0] l2_pix,
  input  logic [1:0]  l2_fmt,
  input  logic        l2_en,
  input  logic [7:0]  l2_alpha,
  input  logic [23:0] bg_color,
  input  logic [1:0]  out_fmt,
  input  logic        dith_en,
  output logic        o_valid,
  input  logic        o_ready,
  output logic [23:0] o_pix
);
  localparam int NL = 2;

  logic              adv;
  logic [NL-1:0][31:0] lpix;
  logic [NL-1:0][1:0]  lfmt;
  logic [NL-1:0]       len;
  logic [NL-1:0][7:0]  lca;
  argb_t             ex [NL];

  assign adv     = o_ready;
  assign i_ready = o_ready;
  assign lpix = {l2_pix, l1_pix};
  assign lfmt = {l2_fmt, l1_fmt};
  assign len  = {l2_en, l1_en};
  assign lca  = {l2_alpha, l1_alpha};

  for (genvar l = 0; l < NL; l++) begin : g_layer
    pc_expand u_exp (.pix(lpix[l]), .fmt(lfmt[l]), .en(len[l]), .calpha(lca[l]), .px(ex[l]));
  end

  // stage 1: widened layers plus captured configuration
  logic       v1, de1, v2, de2;
  argb_t      p1a, p1b, p2b;
  rgb_t       bg1, mix2, m1, m2, dq;
  logic [1:0] of1, of2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; p1a <= '0; p1b <= '0; bg1 <= '0; of1 <= '0; de1 <= 1'b0;
      v2 <= 1'b0; mix2 <= '0; p2b <= '0; of2 <= '0; de2 <= 1'b0;
      o_valid <= 1'b0; o_pix <= '0;
    end else if (adv) begin
      v1 <= i_valid; p1a <= ex[0]; p1b <= ex[1];
      bg1 <= bg_color; of1 <= out_fmt; de1 <= dith_en;
      v2 <= v1; mix2 <= m1; p2b <= p1b; of2 <= of1; de2 <= de1;
      o_valid <= v2; o_pix <= dq;
    end
  end

  pc_blend u_blend1 (.clk(clk), .rst(rst), .fg(p1a), .bg(bg1), .mix(m1));
  pc_blend u_blend2 (.clk(clk), .rst(rst), .fg(p2b), .bg(mix2), .mix(m2));

  pc_dither #(.SEED(LFSR_SEED)) u_dith (
    .clk(clk), .rst(rst), .step(adv && v2), .din(m2),
    .ofmt(of2), .den(de2), .dout(dq)
  );

  // cycles since reset, saturating, for history-based checks
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(o_ready) && $past(o_ready, 2) && $past(o_ready, 3))
      |-> (o_valid == $past(i_valid, 3)));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(o_ready)) |-> ($stable(o_pix) && $stable(o_valid)));
endmodule

// File: tb/pix_compose_test.sv
module pix_compose_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        i_valid = 1'b0, i_ready, o_valid, o_ready = 1'b1;
  logic [31:0] l1_pix = '0, l2_pix = '0;
  logic [1:0]  l1_fmt = '0, l2_fmt = '0, out_fmt = '0;
  logic        l1_en = 1'b0, l2_en = 1'b0, dith_en = 1'b0;
  logic [7:0]  l1_alpha = 8'hFF, l2_alpha = 8'hFF;
  logic [23:0] bg_color = '0, o_pix;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mlf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_compose uut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_exp(input logic [31:0] p, input logic [1:0] f, input logic en, input logic [7:0] ca);
    logic [7:0] a, r, g, b;
    a = 8'hFF; r = p[23:16]; g = p[15:8]; b = p[7:0];
    if (f == 2'd0) a = p[31:24];
    else if (f == 2'd2) begin
      r = {p[15:11], p[15:13]}; g = {p[10:5], p[10:9]}; b = {p[4:0], p[4:2]};
    end else if (f == 2'd3) a = 8'h00;
    if (!en) a = 8'h00;
    a = 8'((int'(a) * int'(ca)) / 255);
    return {a, r, g, b};
  endfunction

  function automatic logic [23:0] m_blend(input logic [31:0] fg, input logic [23:0] under);
    logic [23:0] res;
    for (int c = 0; c < 3; c++)
      res[c*8 +: 8] = 8'((int'(fg[31:24]) * int'(fg[c*8 +: 8]) +
                         (255 - int'(fg[31:24])) * int'(under[c*8 +: 8])) / 255);
    return res;
  endfunction

  function automatic logic [7:0] m_red(input logic [7:0] c, input int keep, input logic [1:0] rn, input logic de);
    int s;
    if (keep == 8) return c;
    s = int'(c) + (de ? int'(rn) : 0);
    if (s > 255) s = 255;
    return 8'(s) & (8'hFF << (8 - keep));
  endfunction

  function automatic logic [23:0] model();
    logic [23:0] c;
    int kr, kg;
    c = m_blend(m_exp(l2_pix, l2_fmt, l2_en, l2_alpha),
                m_blend(m_exp(l1_pix, l1_fmt, l1_en, l1_alpha), bg_color));
    kr = (out_fmt == 2'd1) ? 6 : (out_fmt == 2'd2) ? 5 : 8;
    kg = (out_fmt == 2'd1 || out_fmt == 2'd2) ? 6 : 8;
    return {m_red(c[23:16], kr, mlf[5:4], dith_en),
            m_red(c[15:8], kg, mlf[3:2], dith_en),
            m_red(c[7:0], kr, mlf[1:0], dith_en)};
  endfunction

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // present one beat, wait out the pipeline, compare
  task automatic send_one(input string req, input logic [23:0] fixed, input bit use_fixed);
    logic [23:0] e;
    @(negedge clk);
    i_valid = 1'b1;
    e = use_fixed ? fixed : model();
    mlf = lf_next(mlf);
    @(negedge clk); i_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(req, "o_valid", 32'(o_valid), 32'd1);
    check(req, "o_pix", 32'(o_pix), 32'(e));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "o_valid in reset", 32'(o_valid), 0);
    check("R1", "o_pix in reset", 32'(o_pix), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "o_valid after reset", 32'(o_valid), 0);
    check("R1", "o_pix after reset", 32'(o_pix), 0);
    check("R10", "i_ready follows o_ready", 32'(i_ready), 1);
  endtask

  task automatic t_expand();
    bg_color = 24'h000000; l2_en = 0; out_fmt = 0; dith_en = 0;
    l1_en = 1; l1_alpha = 8'hFF;
    l1_fmt = 2'd2; l1_pix = 32'hFFFF_8410; send_one("R2", 24'h848284, 1);
    l1_fmt = 2'd2; l1_pix = 32'h0000_F81F; send_one("R2", 24'hFF00FF, 1);
    l1_fmt = 2'd1; l1_pix = 32'h00_12_34_56; send_one("R2", 24'h123456, 1);
    l1_fmt = 2'd0; l1_pix = 32'hFF_AB_CD_EF; send_one("R2", 24'hABCDEF, 1);
  endtask

  task automatic t_alpha();
    bg_color = 24'h000000; l1_en = 1; l2_en = 0; out_fmt = 0; dith_en = 0;
    l1_fmt = 2'd0; l1_pix = 32'h80_FF_00_00; l1_alpha = 8'h80;
    send_one("R3", 24'h400000, 1);
    l1_fmt = 2'd1; l1_pix = 32'h00_C8_64_32; l1_alpha = 8'h55; bg_color = 24'h204060;
    send_one("R3", 24'h000000, 0);
    l1_alpha = 8'hFF;
  endtask

  task automatic t_order();
    out_fmt = 0; dith_en = 0; bg_color = 24'h0000FF;
    l1_en = 1; l1_fmt = 2'd1; l1_pix = 32'h0000FF00; l1_alpha = 8'hFF;
    l2_en = 1; l2_fmt = 2'd0; l2_pix = 32'h00FF0000; l2_alpha = 8'hFF;
    send_one("R4", 24'h00FF00, 1);
    l2_pix = 32'hFFFF0000; send_one("R4", 24'hFF0000, 1);
    l1_en = 0; l2_en = 0; send_one("R4", 24'h0000FF, 1);
    l1_en = 1; l1_fmt = 2'd3; send_one("R4", 24'h0000FF, 1);
    l1_fmt = 2'd0; l1_pix = 32'h90_3C_A0_10; l2_en = 1; l2_pix = 32'h60_F0_20_C0; l2_alpha = 8'hC0;
    send_one("R4", 24'h0, 0);
    l2_en = 0;
  endtask

  task automatic t_reduce();
    l1_en = 1; l1_fmt = 2'd1; l1_pix = 32'h008F4B2D; l1_alpha = 8'hFF; l2_en = 0;
    dith_en = 0;
    out_fmt = 2'd2; send_one("R7", 24'h884828, 1);
    out_fmt = 2'd1; send_one("R5", 24'h8C482C, 1);
    out_fmt = 2'd3; send_one("R5", 24'h8F4B2D, 1);
    dith_en = 1; out_fmt = 2'd0; send_one("R7", 24'h8F4B2D, 1);
    dith_en = 0;
  endtask

  task automatic t_dither();
    l1_en = 1; l1_fmt = 2'd1; l1_alpha = 8'hFF; l2_en = 0; bg_color = 0;
    dith_en = 1;
    for (int k = 0; k < 6; k++) begin
      l1_pix = 32'h9E3779B9 * (k + 3);
      out_fmt = (k % 2 == 0) ? 2'd1 : 2'd2;
      send_one("R6", 24'h0, 0);
    end
    l1_pix = 32'h00FFFFFF; out_fmt = 2'd2; send_one("R6", 24'hF8FCF8, 1);
    out_fmt = 2'd1; send_one("R6", 24'hFCFCFC, 1);
    dith_en = 0; l1_pix = 32'h00444444; send_one("R8", 24'h0, 0);
    send_one("R8", 24'h0, 0);
    dith_en = 1; l1_pix = 32'h00437A11; send_one("R8", 24'h0, 0);
    dith_en = 0;
  endtask

  task automatic t_stream();
    logic [23:0] e [4];
    logic [31:0] pv [4];
    logic [1:0]  fv [4];
    pv[0] = 32'h0000F800; fv[0] = 2'd2;
    pv[1] = 32'h00112233; fv[1] = 2'd1;
    pv[2] = 32'hFF445566; fv[2] = 2'd0;
    pv[3] = 32'h000007E0; fv[3] = 2'd2;
    l1_en = 1; l1_alpha = 8'hFF; l2_en = 0; out_fmt = 0; dith_en = 0;
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      check("R9", "stream o_valid", 32'(o_valid), (c >= 3 && c <= 6) ? 1 : 0);
      if (c >= 3 && c <= 6) check("R9", "stream o_pix", 32'(o_pix), 32'(e[c-3]));
      if (c < 4) begin
        l1_pix = pv[c]; l1_fmt = fv[c]; i_valid = 1'b1;
        e[c] = model(); mlf = lf_next(mlf);
      end else i_valid = 1'b0;
    end
  endtask

  task automatic t_stall();
    logic [23:0] e;
    l1_en = 1; l1_fmt = 2'd1; l1_pix = 32'h00A1B2C3; l2_en = 0; out_fmt = 2'd1; dith_en = 1;
    @(negedge clk); i_valid = 1'b1; e = model(); mlf = lf_next(mlf);
    @(negedge clk); i_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "o_valid before stall", 32'(o_valid), 1);
    o_ready = 1'b0; i_valid = 1'b1; l1_pix = 32'h00000000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", "held o_valid", 32'(o_valid), 1);
      check("R10", "held o_pix", 32'(o_pix), 32'(e));
      check("R10", "i_ready low", 32'(i_ready), 0);
    end
    i_valid = 1'b0; o_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10", "refused beat absent", 32'(o_valid), 0);
    end
    l1_pix = 32'h00C0FFEE; send_one("R10", 24'h0, 0);
    dith_en = 0;
  endtask

  initial begin
    t_reset();
    t_expand();
    t_alpha();
    t_order();
    t_reduce();
    t_dither();
    t_stream();
    t_stall();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule